// File: doc/BRIEF.md
# Sector Patch Engine

This block lets a host write an arbitrary run of bytes into a serial flash that can only be erased one whole sector at a time. A request carries a start offset and a byte count. The engine checks the request against the size of the array. It then visits each affected sector from the lowest address upward. For each sector it copies the whole sector into an on-chip buffer and patches in the new bytes. It then erases the sector and programs the buffer back in bounded chunks. Bytes in the first and last sectors that fall outside the requested span keep their old values.

Flash traffic goes through an external command sequencer and nothing else. The engine issues a command with an opcode, an address and a length. For a read, the sequencer then streams bytes in. For a program, it streams bytes out. Each command ends with a completion pulse that carries an error bit. The host does not push data. Instead, the engine asks for each byte by its position within the request, and the host answers with the byte at that position.

All streams use valid/ready. A transfer happens on a clock edge where both are high. Once a source raises valid, it holds valid and its payload steady until ready is seen. Sinks may stall for any number of cycles. `cmd_done`/`cmd_err`, `done`/`done_err`/`done_count` and the request fields are plain control signals.

Top module: `sector_patch_engine`

## Requirements
- R1: A request with nonzero length whose last byte (offset+length-1) lies at or beyond NUM_SECT*2^SECT_LG is rejected. `done` pulses with `done_err`=1 and `done_count`=0, and no flash command or host fetch takes place.
- R2: A request of length zero completes with `done_err`=0 and `done_count`=0, and issues no flash command.
- R3: The sectors from offset/2^SECT_LG through (offset+length-1)/2^SECT_LG are each processed exactly once, in ascending order.
- R4: For each sector, the commands are issued in this order: read (op 0) at the sector base for the full sector length, then erase (op 1) at the sector base with the sector length, then the program commands (op 2).
- R5: After a successful request, every byte in [offset, offset+length) holds the host byte at index (address − offset). Every other byte of the array keeps its earlier value.
- R6: Host bytes are fetched with `wd_idx` = address − offset. The indexes run upward by one, start at 0 and are never ≥ length. `wd_idx` stays steady while `wd_ready` waits for `wd_valid`.
- R7: Write-back covers the sector with program commands of at most PROG_BYTES bytes each, at contiguous ascending addresses starting at the sector base.
- R8: A completion with `cmd_err`=1 on a read, erase or program stops all further commands. `done` then pulses with `done_err`=1 and `done_count`=0.
- R9: A successful request ends with a single-cycle `done`, with `done_err`=0 and `done_count` equal to the request length.
- R10: `req_ready` is high only while idle, and no sequencer or host stream is active then. A pending command holds its op, address and length steady until `cmd_ready`.
- R11: `rd_ready`, `wd_ready`, `pd_valid` and `cmd_valid` are mutually exclusive. `pd_data` stays steady while `pd_valid` waits for `pd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_valid | input | 1 | request present |
| req_ready | output | 1 | engine idle, request accepted |
| req_offset | input | ADDR_W | first byte address |
| req_len | input | LEN_W | byte count |
| wd_ready | output | 1 | engine wants host byte `wd_idx` |
| wd_idx | output | LEN_W | position of wanted byte in the request |
| wd_valid | input | 1 | host byte present |
| wd_data | input | 8 | host byte |
| cmd_valid | output | 1 | sequencer command pending |
| cmd_ready | input | 1 | sequencer takes command |
| cmd_op | output | 2 | 0 read, 1 erase, 2 program |
| cmd_addr | output | ADDR_W | flash address |
| cmd_len | output | SECT_LG+1 | byte count of command |
| rd_valid | input | 1 | read byte present |
| rd_data | input | 8 | read byte |
| rd_ready | output | 1 | engine takes read byte |
| pd_valid | output | 1 | program byte present |
| pd_data | output | 8 | program byte |
| pd_ready | input | 1 | sequencer takes program byte |
| cmd_done | input | 1 | command completion pulse |
| cmd_err | input | 1 | completion carries failure |
| done | output | 1 | request finished pulse |
| done_err | output | 1 | request failed or rejected |
| done_count | output | LEN_W | bytes accepted |

## Verification
A wrong window bound in the buffer shows up after the next write-back. Bytes next to the requested span change in the flash image, or host fetches run past the request length, and both are visible at the end of that sector's program phase. A wrong sector or phase counter shows at once in the command stream, as a command with the wrong op or address. A broken abort path shows as commands after a failing completion, or as a wrong `done_count`, within a few cycles of that completion. Skipping the erase shows as corrupted data, because the model sequencer's program can only clear bits.

// File: rtl/spe_pkg.sv
package spe_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_ERASE = 2'd1,
    OP_PROG  = 2'd2
  } spe_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_RD_CMD, S_RD_DAT, S_RD_WAIT, S_OVL, S_ER_CMD,
    S_ER_WAIT, S_PG_CMD, S_PG_FETCH, S_PG_SEND, S_PG_WAIT, S_DONE
  } spe_state_e;
endpackage

// File: rtl/spe_buf.sv
module spe_buf #(
  parameter int DEPTH_LG = 4
) (
  input  logic                clk,
  input  logic                we,
  input  logic [DEPTH_LG-1:0] addr,
  input  logic [7:0]          wdata,
  output logic [7:0]          rdata
);
  localparam int DEPTH = 1 << DEPTH_LG;
  logic [7:0] mem [DEPTH];

  // one port: write or registered read each cycle
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/spe_span.sv
module spe_span #(
  parameter int ADDR_W   = 24,
  parameter int LEN_W    = 16,
  parameter int SECT_LG  = 4,
  parameter int NUM_SECT = 8,
  localparam int SEC_W   = $clog2(NUM_SECT)
) (
  input  logic [ADDR_W-1:0]  offset,
  input  logic [LEN_W-1:0]   len,
  input  logic [SEC_W-1:0]   sec,
  output logic               in_range,
  output logic [SEC_W-1:0]   first_sec,
  output logic [SEC_W-1:0]   last_sec,
  output logic [SECT_LG-1:0] win_lo,
  output logic [SECT_LG-1:0] win_hi
);
  localparam int W = ADDR_W + 1;
  logic [W-1:0] last_a;
  logic [W-1:0] total;

  assign last_a    = W'(offset) + W'(len) - W'(1);
  assign total     = W'(NUM_SECT) << SECT_LG;
  assign in_range  = (W'(offset) < total) && (last_a < total);
  assign first_sec = SEC_W'(offset >> SECT_LG);
  assign last_sec  = SEC_W'(last_a >> SECT_LG);
  // clip the patch window to both the request and the sector
  assign win_lo    = (sec == first_sec) ? offset[SECT_LG-1:0] : '0;
  assign win_hi    = (sec == last_sec) ? last_a[SECT_LG-1:0] : '1;
endmodule

// File: rtl/sector_patch_engine.sv
module sector_patch_engine
  import spe_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 16,
  parameter int SECT_LG    = 4,
  parameter int NUM_SECT   = 8,
  parameter int PROG_BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_offset,
  input  logic [LEN_W-1:0]   req_len,
  output logic               wd_ready,
  output logic [LEN_W-1:0]   wd_idx,
  input  logic               wd_valid,
  input  logic [7:0]         wd_data,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [1:0]         cmd_op,
  output logic [ADDR_W-1:0]  cmd_addr,
  output logic [SECT_LG:0]   cmd_len,
  input  logic               rd_valid,
  input  logic [7:0]         rd_data,
  output logic               rd_ready,
  output logic               pd_valid,
  output logic [7:0]         pd_data,
  input  logic               pd_ready,
  input  logic               cmd_done,
  input  logic               cmd_err,
  output logic               done,
  output logic               done_err,
  output logic [LEN_W-1:0]   done_count
);
  localparam int SEC_W = $clog2(NUM_SECT);
  localparam logic [SECT_LG:0] SECT_N = (SECT_LG+1)'(1 << SECT_LG);
  localparam logic [SECT_LG:0] PROG_N = (SECT_LG+1)'(PROG_BYTES);

  spe_state_e          st;
  logic [ADDR_W-1:0]   off_q;
  logic [LEN_W-1:0]    len_q;
  logic [SEC_W-1:0]    sec_q;
  logic [SECT_LG:0]    idx_q;
  logic [SECT_LG:0]    left_q;
  logic                err_q;

  logic                in_range;
  logic [SEC_W-1:0]    first_sec, last_sec;
  logic [SECT_LG-1:0]  win_lo, win_hi;
  logic [SECT_LG:0]    remain, chunk;
  logic [ADDR_W-1:0]   base_addr, cur_addr;
  logic                buf_we;
  logic [7:0]          buf_wdata, buf_rdata;

  spe_span #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SECT_LG(SECT_LG), .NUM_SECT(NUM_SECT)) u_span (
    .offset(off_q), .len(len_q), .sec(sec_q), .in_range(in_range),
    .first_sec(first_sec), .last_sec(last_sec), .win_lo(win_lo), .win_hi(win_hi)
  );

  assign buf_we    = (st == S_RD_DAT && rd_valid) || (st == S_OVL && wd_valid);
  assign buf_wdata = (st == S_RD_DAT) ? rd_data : wd_data;

  spe_buf #(.DEPTH_LG(SECT_LG)) u_buf (
    .clk(clk), .we(buf_we), .addr(idx_q[SECT_LG-1:0]), .wdata(buf_wdata), .rdata(buf_rdata)
  );

  assign base_addr = ADDR_W'({sec_q, {SECT_LG{1'b0}}});
  assign cur_addr  = ADDR_W'({sec_q, idx_q[SECT_LG-1:0]});
  assign remain    = SECT_N - idx_q;
  assign chunk     = (remain < PROG_N) ? remain : PROG_N;

  assign req_ready  = (st == S_IDLE);
  assign cmd_valid  = (st == S_RD_CMD) || (st == S_ER_CMD) || (st == S_PG_CMD);
  assign cmd_op     = (st == S_RD_CMD) ? OP_READ : (st == S_ER_CMD) ? OP_ERASE : OP_PROG;
  assign cmd_addr   = (st == S_PG_CMD) ? cur_addr : base_addr;
  assign cmd_len    = (st == S_PG_CMD) ? chunk : SECT_N;
  assign rd_ready   = (st == S_RD_DAT);
  assign wd_ready   = (st == S_OVL);
  assign wd_idx     = LEN_W'(cur_addr - off_q);
  assign pd_valid   = (st == S_PG_SEND);
  assign pd_data    = buf_rdata;
  assign done       = (st == S_DONE);
  assign done_err   = err_q;
  assign done_count = err_q ? '0 : len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      off_q  <= '0;
      len_q  <= '0;
      sec_q  <= '0;
      idx_q  <= '0;
      left_q <= '0;
      err_q  <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (req_valid) begin
          off_q <= req_offset;
          len_q <= req_len;
          err_q <= 1'b0;
          st    <= S_CHK;
        end
        S_CHK: begin
          idx_q <= '0;
          sec_q <= first_sec;
          if (len_q == '0) st <= S_DONE;
          else if (!in_range) begin
            err_q <= 1'b1;
            st    <= S_DONE;
          end else st <= S_RD_CMD;
        end
        S_RD_CMD: if (cmd_ready) st <= S_RD_DAT;
        S_RD_DAT: if (rd_valid) begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == SECT_N - 1'b1) st <= S_RD_WAIT;
        end
        S_RD_WAIT: if (cmd_done) begin
          if (cmd_err) begin
            err_q <= 1'b1;
            st    <= S_DONE;
          end else begin
            idx_q <= {1'b0, win_lo};
            st    <= S_OVL;
          end
        end
        S_OVL: if (wd_valid) begin
          if (idx_q[SECT_LG-1:0] == win_hi) st <= S_ER_CMD;
          else idx_q <= idx_q + 1'b1;
        end
        S_ER_CMD: if (cmd_ready) st <= S_ER_WAIT;
        S_ER_WAIT: if (cmd_done) begin
          if (cmd_err) begin
            err_q <= 1'b1;
            st    <= S_DONE;
          end else begin
            idx_q <= '0;
            st    <= S_PG_CMD;
          end
        end
        S_PG_CMD: if (cmd_ready) begin
          left_q <= chunk;
          st     <= S_PG_FETCH;
        end
        S_PG_FETCH: st <= S_PG_SEND;
        S_PG_SEND: if (pd_ready) begin
          idx_q  <= idx_q + 1'b1;
          left_q <= left_q - 1'b1;
          st     <= (left_q == 1) ? S_PG_WAIT : S_PG_FETCH;
        end
        S_PG_WAIT: if (cmd_done) begin
          if (cmd_err) begin
            err_q <= 1'b1;
            st    <= S_DONE;
          end else if (idx_q != SECT_N) st <= S_PG_CMD;
          else if (sec_q == last_sec) st <= S_DONE;
          else begin
            sec_q <= sec_q + 1'b1;
            idx_q <= '0;
            st    <= S_RD_CMD;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spe_chk.sv
module spe_chk #(
  parameter int ADDR_W  = 24,
  parameter int LEN_W   = 16,
  parameter int SECT_LG = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [SECT_LG:0]  cmd_len,
  input logic              rd_ready,
  input logic              wd_ready,
  input logic              wd_valid,
  input logic [LEN_W-1:0]  wd_idx,
  input logic              pd_valid,
  input logic              pd_ready,
  input logic [7:0]        pd_data,
  input logic              done,
  input logic              done_err,
  input logic [LEN_W-1:0]  done_count
);
  // R10
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_addr) && $stable(cmd_len));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid && !wd_ready && !rd_ready && !pd_valid);
  // R11
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_valid && !pd_ready |=> pd_valid && $stable(pd_data));
  // R11
  one_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, rd_ready, wd_ready, pd_valid}));
  // R6
  wd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ready && !wd_valid |=> wd_ready && $stable(wd_idx));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  err_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_err |-> done_count == '0);
endmodule

bind sector_patch_engine spe_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SECT_LG(SECT_LG)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
  .rd_ready(rd_ready), .wd_ready(wd_ready), .wd_valid(wd_valid), .wd_idx(wd_idx),
  .pd_valid(pd_valid), .pd_ready(pd_ready), .pd_data(pd_data), .done(done),
  .done_err(done_err), .done_count(done_count)
);

// File: tb/sector_patch_engine_tb_top.sv
module sector_patch_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24, LEN_W = 16, SLG = 4, NSEC = 8, PB = 4;
  localparam int SECT = 1 << SLG;
  localparam int TOT  = SECT * NSEC;
  localparam int M_IDLE = 0, M_RD = 1, M_PG = 2, M_FIN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [ADDR_W-1:0] req_offset = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic wd_ready, wd_valid;
  logic [LEN_W-1:0] wd_idx;
  logic [7:0] wd_data;
  logic cmd_valid, cmd_ready;
  logic [1:0] cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic [SLG:0] cmd_len;
  logic rd_valid, rd_ready, pd_valid, pd_ready, cmd_done, cmd_err;
  logic [7:0] rd_data, pd_data;
  logic done, done_err;
  logic [LEN_W-1:0] done_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_patch_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SECT_LG(SLG), .NUM_SECT(NSEC), .PROG_BYTES(PB)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_offset(req_offset), .req_len(req_len), .wd_ready(wd_ready), .wd_idx(wd_idx),
    .wd_valid(wd_valid), .wd_data(wd_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_ready(rd_ready), .pd_valid(pd_valid), .pd_data(pd_data),
    .pd_ready(pd_ready), .cmd_done(cmd_done), .cmd_err(cmd_err), .done(done),
    .done_err(done_err), .done_count(done_count)
  );

  // request context, written only by the stimulus process
  logic [7:0] host_m [256];
  logic [7:0] ref_m [TOT];
  logic go_tog = 1'b0;
  int t_first = 0, t_last = -1, t_len = 0, inj_op = 3, inj_sec = 0;

  // sequencer and host model state, written only by the model process
  logic [7:0] flash_m [TOT];
  logic seen_go;
  int mode, cnt, m_op, m_addr, m_len, fin_wait;
  int e_sec, e_step, e_pg, e_dead, h_next, h_bad, c_bad, ncmd;
  logic pf_cmd, pf_rd, pf_pd, pf_wd;
  logic [1:0] c_op;
  int c_addr, c_len, w_idx;
  logic [7:0] p_dat;

  int total = 0, bad = 0;

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // sequencer + host model: acts on handshakes seen at the previous negedge
  always @(negedge clk) begin
    if (!rst_n) begin
      cmd_ready = 0; rd_valid = 0; rd_data = 0; pd_ready = 0; cmd_done = 0; cmd_err = 0;
      wd_valid = 0; wd_data = 0; mode = M_IDLE; cnt = 0; fin_wait = 0;
      pf_cmd = 0; pf_rd = 0; pf_pd = 0; pf_wd = 0; seen_go = go_tog;
      e_sec = 0; e_step = 0; e_pg = 0; e_dead = 0; h_next = 0; h_bad = 0; c_bad = 0; ncmd = 0;
      for (int i = 0; i < TOT; i++) flash_m[i] = 8'($urandom);
    end else begin
      if (go_tog != seen_go) begin
        seen_go = go_tog; e_sec = t_first; e_step = 0; e_pg = 0; e_dead = 0;
        h_next = 0; h_bad = 0; c_bad = 0; ncmd = 0;
      end
      if (pf_cmd) begin
        ncmd++;
        cmd_ready = 0;
        if (e_dead != 0 || e_sec > t_last) c_bad++;
        else begin
          int base, el;
          base = e_sec * SECT;
          if (e_step == 0) begin
            if (c_op != 2'd0 || c_addr != base || c_len != SECT) c_bad++;
            e_step = 1;
          end else if (e_step == 1) begin
            if (c_op != 2'd1 || c_addr != base || c_len != SECT) c_bad++;
            e_step = 2; e_pg = 0;
          end else begin
            el = imin(PB, SECT - e_pg);
            if (c_op != 2'd2 || c_addr != base + e_pg || c_len != el) c_bad++;
            e_pg += el;
            if (e_pg >= SECT) begin e_sec++; e_step = 0; end
          end
        end
        m_op = int'(c_op); m_addr = c_addr; m_len = c_len; cnt = 0;
        if (m_op == 0) mode = M_RD;
        else if (m_op == 2) mode = M_PG;
        else begin mode = M_FIN; fin_wait = int'($urandom % 3); end
      end
      if (pf_rd) begin
        cnt++;
        if (cnt == m_len) begin rd_valid = 0; mode = M_FIN; fin_wait = int'($urandom % 3); end
      end
      if (pf_pd) begin
        flash_m[(m_addr + cnt) % TOT] = flash_m[(m_addr + cnt) % TOT] & p_dat;
        cnt++;
        if (cnt == m_len) begin pd_ready = 0; mode = M_FIN; fin_wait = int'($urandom % 3); end
      end
      if (pf_wd) begin
        if (w_idx != h_next || w_idx >= t_len) h_bad++;
        h_next++;
      end
      case (mode)
        M_IDLE: cmd_ready = ($urandom % 4) != 0;
        M_RD: begin
          rd_valid = ($urandom % 3) != 0;
          rd_data = flash_m[(m_addr + cnt) % TOT];
        end
        M_PG: pd_ready = ($urandom % 3) != 0;
        default: begin
          if (cmd_done) begin
            cmd_done = 0; cmd_err = 0; mode = M_IDLE;
            cmd_ready = ($urandom % 4) != 0;
          end else if (fin_wait == 0) begin
            cmd_done = 1;
            cmd_err = (inj_op == m_op) && (m_addr == inj_sec * SECT);
            if (cmd_err) e_dead = 1;
            else if (m_op == 1)
              for (int i = 0; i < SECT; i++) flash_m[(m_addr + i) % TOT] = 8'hFF;
          end else fin_wait--;
        end
      endcase
      wd_valid = wd_ready && (($urandom % 3) != 0);
      wd_data = host_m[wd_idx[7:0]];
      pf_cmd = cmd_valid && cmd_ready;
      c_op = cmd_op; c_addr = int'(cmd_addr); c_len = int'(cmd_len);
      pf_rd = rd_valid && rd_ready;
      pf_pd = pd_valid && pd_ready; p_dat = pd_data;
      pf_wd = wd_valid && wd_ready; w_idx = int'(wd_idx);
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // iop: 0 read fail, 1 erase fail, 2 program fail, 3 none
  task automatic run_req(input int off, input int len, input int iop, input int isec, input string tag);
    bit valid, exp_err;
    int hexp, plim, lim, n, mism, got_err, got_cnt;
    valid = (len > 0) && (off + len - 1 < TOT);
    exp_err = (len > 0 && !valid) || (valid && iop != 3);
    for (int i = 0; i < 256; i++) host_m[i] = 8'($urandom);
    plim = (iop == 3) ? TOT : isec * SECT;
    lim  = (iop == 0) ? isec * SECT : (isec + 1) * SECT;
    if (!valid) hexp = 0;
    else if (iop == 3) hexp = len;
    else begin
      hexp = imin(off + len, lim) - off;
      if (hexp < 0) hexp = 0;
    end
    for (int i = 0; i < TOT; i++)
      ref_m[i] = (valid && i >= off && i < off + len && i < plim) ? host_m[i - off] : flash_m[i];
    @(negedge clk);
    inj_op = iop; inj_sec = isec; t_len = len;
    t_first = valid ? off / SECT : 0;
    t_last = valid ? (off + len - 1) / SECT : -1;
    go_tog = ~go_tog;
    req_offset = ADDR_W'(off); req_len = LEN_W'(len); req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    n = 0;
    while (!done && n < 6000) begin @(negedge clk); n++; end
    if (!done) begin
      chk(0, {tag, " watchdog"}, n, 6000);
      finish_run();
    end
    got_err = int'(done_err); got_cnt = int'(done_count);
    @(negedge clk);
    chk(!done && req_ready, {tag, " R9 R10 done single pulse then idle"}, int'(done), 0);
    repeat (4) @(negedge clk);
    chk(got_err == int'(exp_err), {tag, " R1 R8 R9 done_err"}, got_err, int'(exp_err));
    chk(got_cnt == (exp_err ? 0 : len), {tag, " R8 R9 done_count"}, got_cnt, exp_err ? 0 : len);
    if (!valid) chk(ncmd == 0, {tag, " R1 R2 no flash command"}, ncmd, 0);
    else chk(c_bad == 0, {tag, " R3 R4 R7 command order"}, c_bad, 0);
    if (valid && iop == 3) chk(e_sec == t_last + 1 && e_step == 0, {tag, " R3 all sectors"}, e_sec, t_last + 1);
    chk(h_bad == 0 && h_next == hexp, {tag, " R6 host fetch"}, h_next, hexp);
    mism = 0;
    for (int i = 0; i < TOT; i++)
      if (!(iop == 2 && valid && i / SECT == isec) && flash_m[i] != ref_m[i]) mism++;
    chk(mism == 0, {tag, " R5 flash image"}, mism, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(req_ready && !done && !cmd_valid, "R10 reset idle", int'(req_ready), 1);
    chk(!rd_ready && !pd_valid && !wd_ready, "R11 reset streams quiet", int'(rd_ready | pd_valid | wd_ready), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run_req(5, 3, 3, 0, "inner");
    run_req(14, 20, 3, 0, "span3");
    run_req(0, TOT, 3, 0, "full");
    run_req(TOT - 1, 1, 3, 0, "lastbyte");
    run_req(SECT, SECT, 3, 0, "exact");
    run_req(10, 0, 3, 0, "R2 zero");
    run_req(TOT - 8, 9, 3, 0, "R1 tail");
    run_req(200, 1, 3, 0, "R1 start");
    run_req(3, 40, 1, 1, "R8 erase");
    run_req(20, 30, 0, 2, "R8 read");
    run_req(40, 10, 2, 2, "R8 prog");
    for (int k = 0; k < 20; k++) begin
      int o, l;
      o = int'($urandom % TOT);
      l = 1 + int'($urandom % (TOT - o));
      run_req(o, l, 3, 0, "rand");
    end
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "global watchdog", 0, 1);
    finish_run();
  end
endmodule